// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a programmed number of data units from a source address to a destination address over a simple single-beat memory master port. Software sets it up through five 32-bit registers: control, source, destination, count and cycle. It then sets the enable bit. Each unit takes two beats: a read beat at the current source address, then a write beat of the same data at the current destination address. After each unit, both addresses are stepped according to their own mode and the count is decremented.

A transfer is started by a request. The request is either software (select code 0), which counts as present whenever the channel is enabled, or one of twenty request lines. Each line can be watched for a rising edge, a falling edge, a high level or a low level. In batch mode a single request moves the whole count back to back. In intermittent mode each request moves one unit, and the engine then waits. When the count reaches zero, the engine sets an end flag, clears its enable bit and pulses an interrupt for one cycle.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset all five registers read zero, `irq` is low and neither `mem_rd` nor `mem_wr` is asserted.
- R2: Registers sit at byte offsets 0x00 control, 0x04 source, 0x08 destination, 0x0C count and 0x10 cycle, and read back as written. The count keeps bits 19:0 and the cycle register keeps bits 7:0. Control fields: select 4:0, source mode 7:5, destination mode 9:8, transfer mode 12:11, unit 14:13, enable 16, request mode 18:17, pending 24, end 31. All other bits read zero.
- R3: With select code 0 and enable set, the engine starts at once. Each unit is a read beat at the source address followed by a write beat, at the destination address, of the exact data returned by the read. Each unit decrements the count by one.
- R4: After each unit, an address with mode code 0 increases by the unit size, code 1 decreases by it, and codes 2 and 3 leave it unchanged. Source and destination follow their own modes independently.
- R5: Unit code 0, 1, 2 and 3 means 1, 2, 4 and 16 bytes, and `mem_size` carries the unit code on every beat.
- R6: Transfer mode code 2 is intermittent: one unit per detected request, after which the engine waits. Any other code is batch: one request moves the whole count without stopping.
- R7: Request mode 0 detects a falling edge, 1 a rising edge, 2 a low level and 3 a high level. An edge that arrives while a unit is in flight is held as pending (control bit 24) and starts one further unit.
- R8: Select code k (1..20) watches `req_lines[k]` only. Activity on other lines, or on any line while enable is clear, moves no data and sets no pending flag.
- R9: When the last unit's write beat completes, the end flag is set and enable is cleared, and `irq` is high for exactly one cycle. Enabling with a count of zero ends the same way without any beat.
- R10: Writing 0 to control bit 31 or bit 24 clears that flag. Writing 1 to either has no effect.
- R11: While `mem_ready` is low, an asserted beat keeps its strobe and its address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_lines | input | 20 | Request lines, indexed 20 down to 1 by select code |
| mem_rd | output | 1 | Read beat request |
| mem_wr | output | 1 | Write beat request |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | Unit code of the beat |
| mem_wdata | output | 128 | Write data |
| mem_rdata | input | 128 | Read data, taken when `mem_ready` is high during a read beat |
| mem_ready | input | 1 | Beat completes on this cycle |
| irq | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
Batch software transfers are run with every unit size and with every pairing of increment, decrement and fixed addressing. These show whether the step size and its sign are applied per side. Intermittent transfers are driven by single pulses, by pulses spaced closer than a unit, and by held levels. These separate one-unit-per-request from back-to-back running, and show whether a pending request survives a busy engine. Pulses on unselected lines, pulses with enable clear, a zero count and a memory that stalls one cycle in three expose wrong line decoding, spurious starts, a missing end path and unstable beats.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_READ  = 2'd1,
    XS_WRITE = 2'd2
  } xfer_state_e;

  localparam logic [7:0] OFS_CTL = 8'h00;
  localparam logic [7:0] OFS_SRC = 8'h04;
  localparam logic [7:0] OFS_DST = 8'h08;
  localparam logic [7:0] OFS_CNT = 8'h0C;
  localparam logic [7:0] OFS_CYC = 8'h10;

  localparam logic [1:0] TM_INTERMITTENT = 2'd2;

  // Bytes moved by one unit for a unit code
  function automatic logic [4:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    mode,
  input  logic [1:0]    unit,
  output logic [AW-1:0] nxt
);
  import dma_pkg::*;

  logic [AW-1:0] step;

  always_comb begin
    step = AW'(unit_bytes(unit));
    case (mode)
      3'd0:    nxt = cur + step;
      3'd1:    nxt = cur - step;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect #(
  parameter int NSRC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC:1] req_lines,
  input  logic [4:0]    sel,
  input  logic [1:0]    rqm,
  input  logic          en,
  output logic          req_event
);
  localparam int PAD = 32;

  logic [PAD-1:0] lines_pad;
  logic [PAD-1:0] prev_pad;
  logic           cur_line;
  logic           prev_line;

  assign lines_pad[0] = 1'b0;
  for (genvar i = 1; i < PAD; i++) begin : g_pad
    if (i <= NSRC) begin : g_live
      assign lines_pad[i] = req_lines[i];
    end else begin : g_tied
      assign lines_pad[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_pad <= '0;
    else        prev_pad <= lines_pad;
  end

  assign cur_line  = lines_pad[sel];
  assign prev_line = prev_pad[sel];

  always_comb begin
    if (!en) begin
      req_event = 1'b0;
    end else if (sel == 5'd0) begin
      req_event = 1'b1;
    end else begin
      case (rqm)
        2'd0:    req_event = prev_line & ~cur_line;
        2'd1:    req_event = ~prev_line & cur_line;
        2'd2:    req_event = ~cur_line;
        default: req_event = cur_line;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 batch,
  input  logic                 cnt_zero,
  input  logic                 cnt_last,
  input  logic                 req_hit,
  input  logic                 mem_ready,
  output dma_pkg::xfer_state_e state,
  output logic                 start,
  output logic                 zero_end,
  output logic                 read_done,
  output logic                 unit_done
);
  import dma_pkg::*;

  xfer_state_e nxt;

  assign start     = (state == XS_IDLE) && en && !cnt_zero && req_hit;
  assign zero_end  = (state == XS_IDLE) && en && cnt_zero;
  assign read_done = (state == XS_READ) && mem_ready;
  assign unit_done = (state == XS_WRITE) && mem_ready;

  always_comb begin
    nxt = state;
    case (state)
      XS_IDLE:  if (start) nxt = XS_READ;
      XS_READ:  if (mem_ready) nxt = XS_WRITE;
      XS_WRITE: if (mem_ready) nxt = (batch && !cnt_last && en) ? XS_READ : XS_IDLE;
      default:  nxt = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= XS_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 20,
  parameter int NSRC   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSRC:1]     req_lines,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              irq
);
  import dma_pkg::*;

  localparam int CYC_W = 8;

  // control fields
  logic [4:0] sel_q;
  logic [2:0] sam_q;
  logic [1:0] dam_q;
  logic [1:0] tm_q;
  logic [1:0] unit_q;
  logic       en_q;
  logic [1:0] rqm_q;
  logic       pend_q;
  logic       xend_q;

  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  count_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [DATA_W-1:0] buf_q;

  // named internal events
  xfer_state_e state;
  logic req_event, start, zero_end, read_done, unit_done;
  logic cnt_zero, cnt_last, finish, is_idle, batch;
  logic wr_ctl, wr_src, wr_dst, wr_cnt, wr_cyc;

  assign cnt_zero = (count_q == '0);
  assign cnt_last = (count_q == CNT_W'(1));
  assign batch    = (tm_q != TM_INTERMITTENT);
  assign is_idle  = (state == XS_IDLE);
  assign finish   = (unit_done && cnt_last) || zero_end;

  assign wr_ctl = reg_wr && (reg_addr == OFS_CTL);
  assign wr_src = reg_wr && (reg_addr == OFS_SRC) && is_idle;
  assign wr_dst = reg_wr && (reg_addr == OFS_DST) && is_idle;
  assign wr_cnt = reg_wr && (reg_addr == OFS_CNT) && is_idle;
  assign wr_cyc = reg_wr && (reg_addr == OFS_CYC);

  dma_req_detect #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst_n(rst_n), .req_lines(req_lines),
    .sel(sel_q), .rqm(rqm_q), .en(en_q), .req_event(req_event)
  );

  dma_xfer_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en_q), .batch(batch),
    .cnt_zero(cnt_zero), .cnt_last(cnt_last), .req_hit(pend_q || req_event),
    .mem_ready(mem_ready), .state(state), .start(start), .zero_end(zero_end),
    .read_done(read_done), .unit_done(unit_done)
  );

  dma_addr_unit #(.AW(ADDR_W)) u_src_step (
    .cur(src_q), .mode(sam_q), .unit(unit_q), .nxt(src_nxt)
  );

  dma_addr_unit #(.AW(ADDR_W)) u_dst_step (
    .cur(dst_q), .mode({1'b0, dam_q}), .unit(unit_q), .nxt(dst_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; sam_q <= '0; dam_q <= '0; tm_q <= '0; unit_q <= '0;
      rqm_q <= '0; en_q <= 1'b0; pend_q <= 1'b0; xend_q <= 1'b0;
      src_q <= '0; dst_q <= '0; count_q <= '0; cyc_q <= '0;
      buf_q <= '0; irq <= 1'b0;
    end else begin
      irq <= finish;
      if (wr_ctl) begin
        sel_q  <= reg_wdata[4:0];
        sam_q  <= reg_wdata[7:5];
        dam_q  <= reg_wdata[9:8];
        tm_q   <= reg_wdata[12:11];
        unit_q <= reg_wdata[14:13];
        rqm_q  <= reg_wdata[18:17];
      end
      // enable: hardware end wins over software
      if (finish)      en_q <= 1'b0;
      else if (wr_ctl) en_q <= reg_wdata[16];
      // end flag: only a written 0 clears it
      if (finish)                        xend_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[31]) xend_q <= 1'b0;
      // pending request
      if (start || finish)                pend_q <= 1'b0;
      else if (req_event)                 pend_q <= 1'b1;
      else if (wr_ctl && !reg_wdata[24])  pend_q <= 1'b0;

      if (unit_done)   src_q <= src_nxt;
      else if (wr_src) src_q <= ADDR_W'(reg_wdata);
      if (unit_done)   dst_q <= dst_nxt;
      else if (wr_dst) dst_q <= ADDR_W'(reg_wdata);
      if (unit_done)   count_q <= count_q - CNT_W'(1);
      else if (wr_cnt) count_q <= reg_wdata[CNT_W-1:0];
      if (wr_cyc) cyc_q <= reg_wdata[CYC_W-1:0];

      if (read_done) buf_q <= mem_rdata;
    end
  end

  assign mem_rd    = (state == XS_READ);
  assign mem_wr    = (state == XS_WRITE);
  assign mem_addr  = mem_rd ? src_q : dst_q;
  assign mem_size  = unit_q;
  assign mem_wdata = buf_q;

  always_comb begin
    case (reg_addr)
      OFS_CTL: reg_rdata = {xend_q, 6'b0, pend_q, 5'b0, rqm_q, en_q, 1'b0,
                            unit_q, tm_q, 1'b0, dam_q, sam_q, sel_q};
      OFS_SRC: reg_rdata = 32'(src_q);
      OFS_DST: reg_rdata = 32'(dst_q);
      OFS_CNT: reg_rdata = 32'(count_q);
      OFS_CYC: reg_rdata = 32'(cyc_q);
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/dma_engine_checker.sv
module dma_engine_checker #(
  parameter int AW = 32,
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          xend_flag,
  input logic          en_flag,
  input logic          unit_done,
  input logic [CW-1:0] count,
  input logic [AW-1:0] src_addr,
  input logic [2:0]    sam,
  input logic [1:0]    unit,
  input logic          mem_rd,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          idle
);
  import dma_pkg::*;

  logic [AW-1:0] step;
  assign step = AW'(unit_bytes(unit));

  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9
  end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (xend_flag && !en_flag));

  // R3
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> (count == $past(count) - CW'(1)));

  // R4
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && sam == 3'd0) |=> (src_addr == $past(src_addr) + $past(step)));

  // R11
  hold_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R8
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !en_flag) |=> !mem_rd);
endmodule

bind dma_channel_engine dma_engine_checker #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .xend_flag(xend_q), .en_flag(en_q),
  .unit_done(unit_done), .count(count_q), .src_addr(src_q), .sam(sam_q),
  .unit(unit_q), .mem_rd(mem_rd), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .idle(is_idle)
);

// File: tb/test_dma_channel_engine.sv
module test_dma_channel_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   reg_addr = 8'h0;
  logic         reg_wr = 1'b0;
  logic [31:0]  reg_wdata = 32'h0;
  logic [31:0]  reg_rdata;
  logic [20:1]  req_lines = '0;
  logic         mem_rd, mem_wr;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic [127:0] mem_wdata, mem_rdata;
  logic         mem_ready = 1'b1;
  logic         irq;

  int errors = 0, checks = 0, cycles = 0, irq_seen = 0, tick = 0;
  int unsigned exp_rd[$];
  int unsigned exp_wr[$];
  logic [127:0] exp_data[$];
  logic [1:0]   exp_unit = 2'd0;
  logic         stall_pend = 1'b0;
  logic [31:0]  stall_addr = 32'h0;

  always #5 clk = ~clk;

  dma_channel_engine i_dma_channel_engine (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_lines(req_lines),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
  );

  function automatic logic [127:0] pattern(input logic [31:0] a);
    return {4{a ^ 32'h5A5A_0000}};
  endfunction
  assign mem_rdata = pattern(mem_addr);

  function automatic int unsigned advance(int unsigned a, int mode, int ucode);
    int sz[4] = '{1, 2, 4, 16};
    if (mode == 0) return a + sz[ucode];
    if (mode == 1) return a - sz[ucode];
    return a;
  endfunction

  function automatic logic [31:0] cw(int sel, int sam, int dam, int tm, int u, int en, int rqm);
    return 32'(sel) | (32'(sam) << 5) | (32'(dam) << 8) | (32'(tm) << 11)
         | (32'(u) << 13) | (32'(en) << 16) | (32'(rqm) << 17);
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory stall pattern: ready low one cycle in three
  always @(negedge clk) begin
    tick <= tick + 1;
    mem_ready <= ((tick % 3) != 1);
  end

  // reference comparison on every clock
  always begin
    @(negedge clk); #2;
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (irq) irq_seen++;
    if (stall_pend) begin
      chk("R11 strobe held", mem_rd, 1'b1);
      chk("R11 address held", mem_addr, stall_addr);
    end
    stall_pend = mem_rd && !mem_ready;
    stall_addr = mem_addr;
    if ((mem_rd || mem_wr) && mem_ready) begin
      chk("R5 beat unit", mem_size, exp_unit);
      if (mem_rd) begin
        if (exp_rd.size() == 0) chk("R8 unexpected read beat", mem_addr, 32'hFFFF_FFFF);
        else begin
          chk("R3 read address", mem_addr, exp_rd.pop_front());
          exp_data.push_back(pattern(mem_addr));
        end
      end else begin
        if (exp_wr.size() == 0) chk("R8 unexpected write beat", mem_addr, 32'hFFFF_FFFF);
        else begin
          chk("R3 write address", mem_addr, exp_wr.pop_front());
          chk("R3 write data", mem_wdata, exp_data.pop_front());
        end
      end
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic plan(int unsigned s, int unsigned d, int sam, int dam, int u, int n,
                      output int unsigned s_end, output int unsigned d_end);
    exp_unit = 2'(u);
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(s); exp_wr.push_back(d);
      s = advance(s, sam, u); d = advance(d, dam, u);
    end
    s_end = s; d_end = d;
  endtask

  task automatic setup(int unsigned s, int unsigned d, int n);
    wr_reg(8'h04, s); wr_reg(8'h08, d); wr_reg(8'h0C, 32'(n));
  endtask

  task automatic wait_done();
    int g = 0;
    while ((exp_rd.size() != 0 || exp_wr.size() != 0) && g < 3000) begin
      @(negedge clk); g++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(int line, logic lvl);
    @(negedge clk); req_lines[line] = lvl;
    @(negedge clk); req_lines[line] = ~lvl;
  endtask

  task automatic batch_case(string tag, int sam, int dam, int u, int n,
                            int unsigned s, int unsigned d);
    int unsigned se, de; logic [31:0] v; int irq0;
    setup(s, d, n);
    plan(s, d, sam, dam, u, n, se, de);
    irq0 = irq_seen;
    wr_reg(8'h00, cw(0, sam, dam, 0, u, 1, 0));
    wait_done();
    rd_reg(8'h04, v); chk({tag, " R4 source end"}, v, se);
    rd_reg(8'h08, v); chk({tag, " R4 destination end"}, v, de);
    rd_reg(8'h0C, v); chk({tag, " R3 count zero"}, v, 0);
    rd_reg(8'h00, v); chk({tag, " R9 end flag set, enable clear"}, v,
                          cw(0, sam, dam, 0, u, 0, 0) | 32'h8000_0000);
    chk({tag, " R9 one irq cycle"}, irq_seen - irq0, 1);
  endtask

  initial begin
    logic [31:0] v;
    int unsigned se, de;
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 5; k++) begin
      rd_reg(8'(k * 4), v); chk("R1 register reset", v, 0);
    end
    chk("R1 irq low", irq, 0);
    chk("R1 no beat", {mem_rd, mem_wr}, 0);

    // R2 readback and field widths
    wr_reg(8'h04, 32'h1234_5678); rd_reg(8'h04, v); chk("R2 source", v, 32'h1234_5678);
    wr_reg(8'h08, 32'h8765_4321); rd_reg(8'h08, v); chk("R2 destination", v, 32'h8765_4321);
    wr_reg(8'h0C, 32'hFFFF_FFFF); rd_reg(8'h0C, v); chk("R2 count width", v, 32'h000F_FFFF);
    wr_reg(8'h10, 32'h0000_01FF); rd_reg(8'h10, v); chk("R2 cycle width", v, 32'h0000_00FF);
    wr_reg(8'h00, cw(7, 2, 1, 2, 3, 0, 3) | 32'h8100_8400);
    rd_reg(8'h00, v); chk("R2 R10 control fields, flags unaffected by 1", v, cw(7, 2, 1, 2, 3, 0, 3));
    wr_reg(8'h00, 0);

    // R3 R4 R5 batch software transfers
    batch_case("inc/inc 4B", 0, 0, 2, 3, 32'h1000, 32'h2000);
    batch_case("dec/fixed 16B", 1, 2, 3, 2, 32'h3000, 32'h4000);
    batch_case("fixed/dec 2B", 2, 1, 1, 4, 32'h500, 32'h600);
    batch_case("inc/inc 1B", 0, 0, 0, 5, 32'h10, 32'h20);
    batch_case("mode3 fixed/inc 1B", 3, 0, 0, 2, 32'h70, 32'h80);

    // R6 R7 intermittent rising edge on line 3
    setup(32'h100, 32'h200, 3);
    plan(32'h100, 32'h200, 0, 0, 0, 3, se, de);
    irq0 = irq_seen;
    wr_reg(8'h00, cw(3, 0, 0, 2, 0, 1, 1));
    repeat (10) @(negedge clk);
    rd_reg(8'h0C, v); chk("R6 waits without request", v, 3);
    pulse(3, 1'b1); repeat (12) @(negedge clk);
    rd_reg(8'h0C, v); chk("R6 one unit per rising edge", v, 2);
    pulse(3, 1'b1); repeat (12) @(negedge clk);
    pulse(3, 1'b1); wait_done();
    rd_reg(8'h00, v); chk("R9 intermittent end", v, cw(3, 0, 0, 2, 0, 0, 1) | 32'h8000_0000);
    chk("R9 intermittent irq", irq_seen - irq0, 1);

    // R7 falling edge on line 5; the return to high must not count
    req_lines[5] = 1'b1;
    setup(32'h300, 32'h400, 2);
    plan(32'h300, 32'h400, 0, 0, 1, 2, se, de);
    wr_reg(8'h00, cw(5, 0, 0, 2, 1, 1, 0));
    repeat (6) @(negedge clk);
    pulse(5, 1'b0); repeat (14) @(negedge clk);
    rd_reg(8'h0C, v); chk("R7 falling edge only", v, 1);
    pulse(5, 1'b0); wait_done();
    rd_reg(8'h0C, v); chk("R7 falling edge second unit", v, 0);
    req_lines[5] = 1'b0;

    // R7 pending: two rising edges closer than a unit
    setup(32'h900, 32'hA00, 3);
    plan(32'h900, 32'hA00, 0, 0, 0, 2, se, de);
    wr_reg(8'h00, cw(3, 0, 0, 2, 0, 1, 1));
    pulse(3, 1'b1); pulse(3, 1'b1);
    repeat (20) @(negedge clk);
    rd_reg(8'h0C, v); chk("R7 pending edge kept during unit", v, 1);
    wr_reg(8'h00, 0);

    // R6 R7 high level, batch on line 2
    setup(32'hB00, 32'hC00, 3);
    plan(32'hB00, 32'hC00, 0, 0, 2, 3, se, de);
    wr_reg(8'h00, cw(2, 0, 0, 0, 2, 1, 3));
    repeat (8) @(negedge clk);
    rd_reg(8'h0C, v); chk("R7 high level absent", v, 3);
    @(negedge clk); req_lines[2] = 1'b1;
    @(negedge clk); req_lines[2] = 1'b0;
    wait_done();
    rd_reg(8'h0C, v); chk("R6 batch finishes on one request", v, 0);

    // R7 low level, intermittent on line 1, held low
    req_lines[1] = 1'b1;
    setup(32'hD00, 32'hE00, 3);
    plan(32'hD00, 32'hE00, 1, 0, 0, 3, se, de);
    wr_reg(8'h00, cw(1, 1, 0, 2, 0, 1, 2));
    repeat (8) @(negedge clk);
    rd_reg(8'h0C, v); chk("R7 low level absent", v, 3);
    @(negedge clk); req_lines[1] = 1'b0;
    wait_done();
    rd_reg(8'h0C, v); chk("R7 held low level keeps requesting", v, 0);
    req_lines[1] = 1'b1;

    // R8 unselected line and disabled channel
    setup(32'hF00, 32'hF80, 2);
    wr_reg(8'h00, cw(3, 0, 0, 2, 0, 1, 1));
    pulse(4, 1'b1); repeat (10) @(negedge clk);
    rd_reg(8'h0C, v); chk("R8 other line ignored", v, 2);
    wr_reg(8'h00, cw(3, 0, 0, 2, 0, 0, 1));
    pulse(3, 1'b1); repeat (10) @(negedge clk);
    rd_reg(8'h0C, v); chk("R8 disabled ignores request", v, 2);
    rd_reg(8'h00, v); chk("R8 no pending while disabled", v[24], 0);

    // R9 zero count ends at once
    setup(32'h40, 32'h50, 0);
    irq0 = irq_seen;
    wr_reg(8'h00, cw(0, 0, 0, 0, 0, 1, 0));
    repeat (4) @(negedge clk);
    rd_reg(8'h00, v); chk("R9 zero count end flag", v, 32'h8000_0000);
    chk("R9 zero count irq", irq_seen - irq0, 1);
    rd_reg(8'h04, v); chk("R9 zero count no step", v, 32'h40);

    // R10 end flag write semantics
    wr_reg(8'h00, 32'h8000_0000);
    rd_reg(8'h00, v); chk("R10 writing 1 keeps end flag", v[31], 1);
    wr_reg(8'h00, 32'h0);
    rd_reg(8'h00, v); chk("R10 writing 0 clears end flag", v[31], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule